// File: doc/BRIEF.md
# Single-Instruction Lockstep Equivalence Sequencer

This block sequences one equivalence run between an instruction-level reference model and a pipelined implementation model of the same processor. The block owns a short fixed timeline. First comes a load step, where both sides receive the same seed data. Next the reference model executes one step and then freezes. While that step runs, the implementation model is held in reset. The implementation then executes a number of steps set by its write-back depth and then freezes too. The block evaluates a single qualified comparison of the architectural resources and latches the verdict.

The instruction under test is built from a constant pattern, a constant-field mask and a free operand input, and it is captured at start. The reference side sees this word directly. The implementation side reads it through a one-shot fetch port: the first fetch of the run returns the instruction and every later fetch returns the no-op word. A selectable data-width reduction masks the shared seed words and publishes the keep mask, so that the models can pin the dropped bits to zero.

Top module: `lockstep_eq_seq`

## Requirements
- R1: After reset the block is idle: `done_o`=0, `pass_o`=0, `load_o`=0, `check_o`=0, `impl_rst_o`=0, both halt outputs are 1 and `cnt_o`=0.
- R2: A `start_i` pulse seen while idle gives exactly one load cycle. In that cycle `load_o`=1, both halts are 1 and `done_o`=0. The run steps follow with `cnt_o` starting at 0 and rising by one per cycle.
- R3: `ref_halt_o` is 0 in run step 0 only, so the reference side executes exactly one step.
- R4: `impl_rst_o` is 1 in run step 0 only. `impl_halt_o` is 0 in steps 1 through T_WB+1 (T_WB+1 cycles) and 1 at all other times.
- R5: `check_o` is 1 in step T_WB+2 only. The block is idle again in the next cycle.
- R6: The verdict latched after the check step is a fail when every `asm_ok_i` bit is 1 and at least one `res_eq_i` bit is 0. It is a pass otherwise. `done_o`=1 and `pass_o` hold this verdict until the next accepted start, which clears `done_o`.
- R7: The instruction word is `(opc_val_i & opc_mask_i) | (free_bits_i & ~opc_mask_i)`, sampled when start is accepted. `ref_fetch_o` shows this captured word, and later input changes do not alter it.
- R8: `fetch_data_o` returns the captured instruction until the first run cycle with `fetch_req_i`=1. After that it returns the no-op word 0x0000 until the next accepted start.
- R9: With the reduction select captured at start, the keep mask is all DW bits for code 0, the low DW/2 bits for code 1, the low DW/4 bits for code 2 and the low DW/8 bits for code 3 (0x0003 for 16-bit words). `red_mask_o` shows this mask and `init_data_o` = `init_data_i & red_mask_o`.
- R10: A `start_i` pulse during load or run steps is ignored, including one in the check step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a run (accepted only when idle) |
| opc_mask_i | input | IW | 1 marks a constant-field bit |
| opc_val_i | input | IW | Constant-field values |
| free_bits_i | input | IW | Free operand bits |
| red_sel_i | input | 2 | Data-width reduction code |
| init_data_i | input | DW | Shared seed word |
| fetch_req_i | input | 1 | Implementation fetch strobe |
| res_eq_i | input | N_RES | Per-resource equality flags |
| asm_ok_i | input | N_ASM | Operand assumption flags |
| load_o | output | 1 | Load shared initial state into both sides |
| init_data_o | output | DW | Reduced seed word |
| red_mask_o | output | DW | Keep mask for data words |
| ref_fetch_o | output | IW | Instruction word for the reference side |
| fetch_data_o | output | IW | One-shot program memory read data |
| ref_halt_o | output | 1 | Hold reference-side resources |
| impl_halt_o | output | 1 | Hold implementation-side resources |
| impl_rst_o | output | 1 | Reset implementation model |
| cnt_o | output | CW | Run step counter |
| check_o | output | 1 | Comparison step strobe |
| done_o | output | 1 | Verdict valid |
| pass_o | output | 1 | Verdict: 1 = equivalent |

## Verification
Two functions can fall in the same cycle: the verdict evaluation in step T_WB+2 and a new start request. The bench raises `start_i` in that check cycle on every run. In the following cycle it checks that the verdict was latched and that no load step began. A second overlap is step 0, where the single reference step and the implementation reset coincide. The bench checks both strobes in that same step across a full sweep of equality and assumption patterns and all four reduction codes.

// File: rtl/eqs_pkg.sv
package eqs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_RUN  = 2'd2
  } eqs_state_e;
endpackage

// File: rtl/eqs_ctrl.sv
module eqs_ctrl
  import eqs_pkg::*;
#(
  parameter int T_WB = 4,
  parameter int CW   = $clog2(T_WB + 3)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          load_o,
  output logic          in_run_o,
  output logic [CW-1:0] cnt_o,
  output logic          ref_halt_o,
  output logic          impl_halt_o,
  output logic          impl_rst_o,
  output logic          check_o
);
  localparam logic [CW-1:0] LastRun = CW'(T_WB + 1);
  localparam logic [CW-1:0] ChkStep = CW'(T_WB + 2);

  eqs_state_e    state_q;
  logic [CW-1:0] cnt_q;

  assign accept_o = (state_q == ST_IDLE) && start_i;
  assign load_o   = (state_q == ST_LOAD);
  assign in_run_o = (state_q == ST_RUN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_LOAD;
          cnt_q   <= '0;
        end
        ST_LOAD: begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN: begin
          if (cnt_q == ChkStep) state_q <= ST_IDLE;
          else                  cnt_q   <= cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cnt_o       = cnt_q;
  assign ref_halt_o  = !(in_run_o && cnt_q == '0);
  assign impl_rst_o  = in_run_o && cnt_q == '0;
  assign impl_halt_o = !(in_run_o && cnt_q != '0 && cnt_q <= LastRun);
  assign check_o     = in_run_o && cnt_q == ChkStep;
endmodule

// File: rtl/eqs_fetch.sv
module eqs_fetch #(
  parameter int          IW       = 16,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          in_run_i,
  input  logic          fetch_req_i,
  input  logic [IW-1:0] opc_mask_i,
  input  logic [IW-1:0] opc_val_i,
  input  logic [IW-1:0] free_bits_i,
  output logic [IW-1:0] ref_fetch_o,
  output logic [IW-1:0] fetch_data_o
);
  logic [IW-1:0] word_d, word_q;
  logic          served_q;

  // per-bit choice between constant field and free operand
  for (genvar b = 0; b < IW; b++) begin : g_bit
    assign word_d[b] = opc_mask_i[b] ? opc_val_i[b] : free_bits_i[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q   <= NOP_WORD;
      served_q <= 1'b0;
    end else if (accept_i) begin
      word_q   <= word_d;
      served_q <= 1'b0;
    end else if (in_run_i && fetch_req_i) begin
      served_q <= 1'b1;
    end
  end

  assign ref_fetch_o  = word_q;
  assign fetch_data_o = served_q ? NOP_WORD : word_q;
endmodule

// File: rtl/eqs_reduce.sv
module eqs_reduce #(
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic [1:0]    red_sel_i,
  input  logic [DW-1:0] init_data_i,
  output logic [DW-1:0] red_mask_o,
  output logic [DW-1:0] init_data_o
);
  localparam int KeepHalf  = DW / 2;
  localparam int KeepQuart = DW / 4;
  localparam int KeepEight = DW / 8;

  logic [1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sel_q <= 2'd0;
    else if (accept_i) sel_q <= red_sel_i;
  end

  for (genvar b = 0; b < DW; b++) begin : g_keep
    localparam bit InHalf  = (b < KeepHalf);
    localparam bit InQuart = (b < KeepQuart);
    localparam bit InEight = (b < KeepEight);
    always_comb begin
      case (sel_q)
        2'd0:    red_mask_o[b] = 1'b1;
        2'd1:    red_mask_o[b] = InHalf;
        2'd2:    red_mask_o[b] = InQuart;
        default: red_mask_o[b] = InEight;
      endcase
    end
  end

  assign init_data_o = init_data_i & red_mask_o;
endmodule

// File: rtl/eqs_verdict.sv
module eqs_verdict #(
  parameter int N_RES = 4,
  parameter int N_ASM = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic             check_i,
  input  logic [N_RES-1:0] res_eq_i,
  input  logic [N_ASM-1:0] asm_ok_i,
  output logic             done_o,
  output logic             pass_o
);
  logic mismatch;
  logic done_q, pass_q;

  // implication: assumptions hold -> every resource equal
  assign mismatch = (&asm_ok_i) && !(&res_eq_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (accept_i) begin
      done_q <= 1'b0;
      pass_q <= 1'b0;
    end else if (check_i) begin
      done_q <= 1'b1;
      pass_q <= !mismatch;
    end
  end

  assign done_o = done_q;
  assign pass_o = pass_q;
endmodule

// File: rtl/lockstep_eq_seq.sv
module lockstep_eq_seq #(
  parameter int          IW       = 16,
  parameter int          DW       = 16,
  parameter int          T_WB     = 4,
  parameter int          N_RES    = 4,
  parameter int          N_ASM    = 2,
  parameter logic [IW-1:0] NOP_WORD = '0,
  parameter int          CW       = $clog2(T_WB + 3)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [IW-1:0]    opc_mask_i,
  input  logic [IW-1:0]    opc_val_i,
  input  logic [IW-1:0]    free_bits_i,
  input  logic [1:0]       red_sel_i,
  input  logic [DW-1:0]    init_data_i,
  input  logic             fetch_req_i,
  input  logic [N_RES-1:0] res_eq_i,
  input  logic [N_ASM-1:0] asm_ok_i,
  output logic             load_o,
  output logic [DW-1:0]    init_data_o,
  output logic [DW-1:0]    red_mask_o,
  output logic [IW-1:0]    ref_fetch_o,
  output logic [IW-1:0]    fetch_data_o,
  output logic             ref_halt_o,
  output logic             impl_halt_o,
  output logic             impl_rst_o,
  output logic [CW-1:0]    cnt_o,
  output logic             check_o,
  output logic             done_o,
  output logic             pass_o
);
  logic accept;
  logic in_run;

  eqs_ctrl #(.T_WB(T_WB), .CW(CW)) u_ctrl (
    .clk_i, .rst_ni, .start_i,
    .accept_o   (accept),
    .load_o,
    .in_run_o   (in_run),
    .cnt_o,
    .ref_halt_o,
    .impl_halt_o,
    .impl_rst_o,
    .check_o
  );

  eqs_fetch #(.IW(IW), .NOP_WORD(NOP_WORD)) u_fetch (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .in_run_i   (in_run),
    .fetch_req_i,
    .opc_mask_i, .opc_val_i, .free_bits_i,
    .ref_fetch_o, .fetch_data_o
  );

  eqs_reduce #(.DW(DW)) u_reduce (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .red_sel_i, .init_data_i,
    .red_mask_o, .init_data_o
  );

  eqs_verdict #(.N_RES(N_RES), .N_ASM(N_ASM)) u_verdict (
    .clk_i, .rst_ni,
    .accept_i   (accept),
    .check_i    (check_o),
    .res_eq_i, .asm_ok_i,
    .done_o, .pass_o
  );
endmodule

// File: rtl/lockstep_eq_seq_chk.sv
module lockstep_eq_seq_chk #(
  parameter int          IW       = 16,
  parameter int          CW       = 3,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          fetch_req_i,
  input logic          load_o,
  input logic [IW-1:0] fetch_data_o,
  input logic          ref_halt_o,
  input logic          impl_halt_o,
  input logic          impl_rst_o,
  input logic [CW-1:0] cnt_o,
  input logic          check_o,
  input logic          done_o,
  input logic          pass_o
);
  p_load_halts_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |-> (ref_halt_o && impl_halt_o && !done_o));

  p_load_then_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o |=> (!ref_halt_o && cnt_o == '0));

  p_sides_exclusive_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_halt_o |-> impl_halt_o);

  p_rst_with_ref_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    impl_rst_o |-> (!ref_halt_o && impl_halt_o));

  p_ref_then_impl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_halt_o |=> !impl_halt_o);

  p_check_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    check_o |=> (done_o && !load_o));

  p_verdict_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> (done_o && $stable(pass_o)));

  p_one_shot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !impl_halt_o) |=> fetch_data_o == NOP_WORD);

  p_busy_start_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !ref_halt_o) |=> !load_o);
endmodule

bind lockstep_eq_seq lockstep_eq_seq_chk #(.IW(IW), .CW(CW), .NOP_WORD(NOP_WORD)) u_chk (
  .clk_i, .rst_ni, .start_i, .fetch_req_i, .load_o, .fetch_data_o,
  .ref_halt_o, .impl_halt_o, .impl_rst_o, .cnt_o, .check_o, .done_o, .pass_o
);

// File: tb/lockstep_eq_seq_tb.sv
module lockstep_eq_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IW = 16;
  localparam int DW = 16;
  localparam int T_WB = 4;
  localparam int N_RES = 4;
  localparam int N_ASM = 2;
  localparam int CW = $clog2(T_WB + 3);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [IW-1:0]    opc_mask = '0, opc_val = '0, free_bits = '0;
  logic [1:0]       red_sel = '0;
  logic [DW-1:0]    init_data = '0;
  logic             fetch_req = 1'b0;
  logic [N_RES-1:0] res_eq = '0;
  logic [N_ASM-1:0] asm_ok = '0;
  logic             load, ref_halt, impl_halt, impl_rst, check, done, pass;
  logic [DW-1:0]    init_out, red_mask;
  logic [IW-1:0]    ref_fetch, fetch_data;
  logic [CW-1:0]    cnt;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  lockstep_eq_seq #(.IW(IW), .DW(DW), .T_WB(T_WB), .N_RES(N_RES), .N_ASM(N_ASM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .opc_mask_i(opc_mask), .opc_val_i(opc_val), .free_bits_i(free_bits),
    .red_sel_i(red_sel), .init_data_i(init_data), .fetch_req_i(fetch_req),
    .res_eq_i(res_eq), .asm_ok_i(asm_ok),
    .load_o(load), .init_data_o(init_out), .red_mask_o(red_mask),
    .ref_fetch_o(ref_fetch), .fetch_data_o(fetch_data),
    .ref_halt_o(ref_halt), .impl_halt_o(impl_halt), .impl_rst_o(impl_rst),
    .cnt_o(cnt), .check_o(check), .done_o(done), .pass_o(pass)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [IW-1:0] instr;
    logic [DW-1:0] kmask;
    bit            exp_pass;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(done == 0 && pass == 0, "R1 verdict", {done, pass}, 0);
    chk(load == 0 && check == 0 && impl_rst == 0, "R1 strobes", {load, check, impl_rst}, 0);
    chk(ref_halt && impl_halt, "R1 halts", {ref_halt, impl_halt}, 3);
    chk(cnt == 0, "R1 cnt", cnt, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int run = 0; run < 64; run++) begin
      res_eq    = N_RES'(run % 16);
      asm_ok    = N_ASM'(run / 16);
      red_sel   = 2'(run % 4);
      opc_mask  = 16'hF00F ^ 16'(run << 4);
      opc_val   = 16'hA5C3 ^ 16'(run * 3);
      free_bits = 16'(run * 16'h1357);
      init_data = 16'hFFFF ^ 16'(run);
      instr     = (opc_val & opc_mask) | (free_bits & ~opc_mask);
      kmask     = (red_sel == 0) ? 16'hFFFF : 16'((32'd1 << (DW >> red_sel)) - 1);
      exp_pass  = !((&asm_ok) && !(&res_eq));
      start     = 1'b1;
      @(negedge clk);
      // load cycle
      start = 1'b0;
      chk(load == 1 && ref_halt && impl_halt, "R2 load cycle", {load, ref_halt, impl_halt}, 7);
      chk(done == 0, "R2 done cleared", done, 0);
      chk(ref_fetch == instr, "R7 instruction word", ref_fetch, instr);
      chk(red_mask == kmask, "R9 keep mask", red_mask, kmask);
      chk(init_out == (init_data & kmask), "R9 reduced seed", init_out, init_data & kmask);
      free_bits = ~free_bits;
      opc_val   = ~opc_val;
      // R8 fetch during load must not consume the one-shot word
      fetch_req = 1'b1;
      for (int s = 0; s <= T_WB + 2; s++) begin
        @(negedge clk);
        if (s == 0) fetch_req = 1'b0;
        chk(cnt == CW'(s), "R2 step count", cnt, s);
        chk(ref_halt == (s != 0), "R3 reference halt", ref_halt, s != 0);
        chk(impl_rst == (s == 0), "R4 impl reset", impl_rst, s == 0);
        chk(impl_halt == !(s >= 1 && s <= T_WB + 1), "R4 impl halt", impl_halt, !(s >= 1 && s <= T_WB + 1));
        chk(check == (s == T_WB + 2), "R5 check strobe", check, s == T_WB + 2);
        if (s == 1) begin
          chk(fetch_data == instr, "R8 first fetch", fetch_data, instr);
          chk(ref_fetch == instr, "R7 captured word", ref_fetch, instr);
          fetch_req = 1'b1;
        end
        if (s == 2) begin
          chk(fetch_data == '0, "R8 second fetch nop", fetch_data, 0);
          fetch_req = 1'b0;
        end
        if (s == T_WB + 1) chk(fetch_data == '0, "R8 later fetch nop", fetch_data, 0);
        if (s == T_WB + 2) start = 1'b1;  // R10 start in check cycle
      end
      @(negedge clk);
      start = 1'b0;
      chk(load == 0 && ref_halt && impl_halt, "R10 start ignored", {load, ref_halt, impl_halt}, 3);
      chk(check == 0, "R5 idle after check", check, 0);
      chk(done == 1 && pass == exp_pass, "R6 verdict", {done, pass}, {1'b1, exp_pass});
      @(negedge clk);
      chk(done == 1 && pass == exp_pass, "R6 verdict held", {done, pass}, {1'b1, exp_pass});
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule